// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block keeps the operand stack of a floating-point unit. It holds eight 80-bit data registers in a ring, a wrapping top pointer, and a 2-bit state tag for each physical register. The execution side names operands relative to the top, as ST(i). The block turns each such name into a physical register number by adding the top pointer, with the sum taken modulo the register count.

Each cycle takes one command: push, pop, result write (with or without a trailing pop), read, free, pointer increment or pointer decrement. Pushing into a register that is still occupied is an overflow. Sourcing an empty register is an underflow. Either fault raises a stack-fault flag and an invalid-operation flag for one cycle, and it leaves the data, the tags and the pointer as they were. A sticky condition bit records which of the two faults occurred. Freeing a register only retags it empty. The stored value and the pointer are untouched. Arithmetic, rounding, memory access and trapping live elsewhere.

Top module: `fpstk_ctrl`

## Requirements
- R1: After a synchronous reset `top_o` is 0, every tag reads empty (`tags_o` all ones), `cc1` is 0, and `stk_flt`, `inv_flt` and `rd_valid` are 0.
- R2: Push (`cmd`=3'd1) onto an empty destination decrements `top_o` modulo 8 (0 becomes 7). It writes `wdata` into the new top register and sets that register's tag to valid 00b. Register p's tag is `tags_o[2p+1:2p]`, and empty is 11b.
- R3: Push when physical register (top-1) mod 8 is not empty is an overflow. The next cycle shows `stk_flt`=1, `inv_flt`=1 and `cc1`=1, with `top_o`, `tags_o` and the stored data unchanged.
- R4: Read (`cmd`=3'd6) of ST(`idx`) returns the contents of physical register (`top_o`+`idx`) mod 8 on `rd_data` one cycle later, with `rd_valid`=1.
- R5: Read of a register whose tag is empty is an underflow. The next cycle shows `stk_flt`=1, `inv_flt`=1, `cc1`=0 and `rd_valid`=0.
- R6: Pop (`cmd`=3'd2) retags the top register empty and increments `top_o` modulo 8. A pop with an empty top register is an underflow (as R5) and changes neither the pointer nor the tags.
- R7: Write (`cmd`=3'd7) stores `wdata` into ST(`idx`) and tags it valid. With `pop_after`=1 the pop of R6 follows the write, so that a value written to ST(1) becomes the new ST(0). With `pop_after`=1 and an empty top, the command is an underflow and writes no data.
- R8: Free (`cmd`=3'd3) sets the tag of ST(`idx`) to empty. It leaves `top_o` and all other tags unchanged.
- R9: Increment (`cmd`=3'd4) adds 1 to `top_o` modulo 8 (7 becomes 0). Decrement (`cmd`=3'd5) subtracts 1 modulo 8. Both clear `cc1` and leave the tags unchanged.
- R10: `stk_flt` and `inv_flt` are always equal and high only in the cycle after a faulting command. `cc1` keeps its value through commands that neither fault nor move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command: 0 none, 1 push, 2 pop, 3 free, 4 increment, 5 decrement, 6 read, 7 write |
| idx | input | 3 | Stack-relative register index i of ST(i) |
| pop_after | input | 1 | Pop after a write command |
| wdata | input | 80 | Data for push and write |
| top_o | output | 3 | Top-of-stack pointer |
| tags_o | output | 16 | Tags of all physical registers, 2 bits each |
| rd_data | output | 80 | Read data, one cycle after a read |
| rd_valid | output | 1 | Read data is valid |
| stk_flt | output | 1 | Stack fault in the previous command |
| inv_flt | output | 1 | Invalid-operation flag raised with a stack fault |
| cc1 | output | 1 | Condition bit: 1 overflow, 0 underflow; cleared by pointer moves |

## Verification
The bench builds the block with its default parameters: eight registers of 80 bits. With these values a run of nine pushes fills the whole ring and reaches the overflow case, and a short run of pointer moves reaches both wrap points of the 3-bit pointer, from 7 to 0 and from 0 to 7. Eight reads after the full ring is built cover every stack-relative index against a known physical placement. Each data word repeats a 16-bit token, so a wrong register shows up in the low bits.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int TAG_W = 2;
  localparam logic [TAG_W-1:0] TAG_VALID = 2'b00;
  localparam logic [TAG_W-1:0] TAG_EMPTY = 2'b11;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_FREE  = 3'd3,
    OP_INC   = 3'd4,
    OP_DEC   = 3'd5,
    OP_READ  = 3'd6,
    OP_WRITE = 3'd7
  } op_e;
endpackage

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 80,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NREG];

  // One write port, one registered read port: block RAM friendly.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fpstk_decode.sv
module fpstk_decode
  import fpstk_pkg::*;
#(
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [2:0]            cmd,
  input  logic [AW-1:0]         idx,
  input  logic                  pop_after,
  input  logic [AW-1:0]         top,
  input  logic [TAG_W*NREG-1:0] tags,
  output logic [AW-1:0]         top_nx,
  output logic                  ovf,
  output logic                  unf,
  output logic                  rd_ok,
  output logic [AW-1:0]         rd_addr,
  output logic                  we,
  output logic [AW-1:0]         waddr,
  output logic                  set_valid,
  output logic [AW-1:0]         valid_addr,
  output logic                  set_empty,
  output logic [AW-1:0]         empty_addr,
  output logic                  cc_clr
);
  logic [AW-1:0] phys, below;
  logic          top_empty, src_empty, below_full;
  op_e           op;

  assign op         = op_e'(cmd);
  assign phys       = top + idx;
  assign below      = top - AW'(1);
  assign top_empty  = tags[TAG_W*top +: TAG_W] == TAG_EMPTY;
  assign src_empty  = tags[TAG_W*phys +: TAG_W] == TAG_EMPTY;
  assign below_full = tags[TAG_W*below +: TAG_W] != TAG_EMPTY;
  assign rd_addr    = phys;

  always_comb begin
    top_nx     = top;
    ovf        = 1'b0;
    unf        = 1'b0;
    rd_ok      = 1'b0;
    we         = 1'b0;
    waddr      = phys;
    set_valid  = 1'b0;
    valid_addr = phys;
    set_empty  = 1'b0;
    empty_addr = top;
    cc_clr     = 1'b0;
    unique case (op)
      OP_PUSH: begin
        if (below_full) ovf = 1'b1;
        else begin
          top_nx     = below;
          we         = 1'b1;
          waddr      = below;
          set_valid  = 1'b1;
          valid_addr = below;
        end
      end
      OP_POP: begin
        if (top_empty) unf = 1'b1;
        else begin
          set_empty = 1'b1;
          top_nx    = top + AW'(1);
        end
      end
      OP_FREE: begin
        set_empty  = 1'b1;
        empty_addr = phys;
      end
      OP_INC: begin
        top_nx = top + AW'(1);
        cc_clr = 1'b1;
      end
      OP_DEC: begin
        top_nx = below;
        cc_clr = 1'b1;
      end
      OP_READ: begin
        if (src_empty) unf = 1'b1;
        else rd_ok = 1'b1;
      end
      OP_WRITE: begin
        if (pop_after && top_empty) unf = 1'b1;
        else begin
          we        = 1'b1;
          set_valid = 1'b1;
          if (pop_after) begin
            set_empty = 1'b1;
            top_nx    = top + AW'(1);
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fpstk_tagfile.sv
module fpstk_tagfile
  import fpstk_pkg::*;
#(
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AW-1:0]         top_nx,
  input  logic                  set_valid,
  input  logic [AW-1:0]         valid_addr,
  input  logic                  set_empty,
  input  logic [AW-1:0]         empty_addr,
  output logic [AW-1:0]         top,
  output logic [TAG_W*NREG-1:0] tags
);
  always_ff @(posedge clk) begin
    if (rst) top <= '0;
    else     top <= top_nx;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_tag
    logic [TAG_W-1:0] tag_q;
    always_ff @(posedge clk) begin
      if (rst)
        tag_q <= TAG_EMPTY;
      else if (set_empty && empty_addr == AW'(g))
        tag_q <= TAG_EMPTY;   // a pop after a write to the same slot wins
      else if (set_valid && valid_addr == AW'(g))
        tag_q <= TAG_VALID;
    end
    assign tags[TAG_W*g +: TAG_W] = tag_q;
  end
endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 80,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            cmd,
  input  logic [AW-1:0]         idx,
  input  logic                  pop_after,
  input  logic [DW-1:0]         wdata,
  output logic [AW-1:0]         top_o,
  output logic [TAG_W*NREG-1:0] tags_o,
  output logic [DW-1:0]         rd_data,
  output logic                  rd_valid,
  output logic                  stk_flt,
  output logic                  inv_flt,
  output logic                  cc1
);
  logic [AW-1:0] top_nx, rd_addr, waddr, valid_addr, empty_addr;
  logic          ovf, unf, rd_ok, we, set_valid, set_empty, cc_clr;

  fpstk_decode #(.NREG(NREG)) u_dec (
    .cmd(cmd), .idx(idx), .pop_after(pop_after), .top(top_o), .tags(tags_o),
    .top_nx(top_nx), .ovf(ovf), .unf(unf), .rd_ok(rd_ok), .rd_addr(rd_addr),
    .we(we), .waddr(waddr), .set_valid(set_valid), .valid_addr(valid_addr),
    .set_empty(set_empty), .empty_addr(empty_addr), .cc_clr(cc_clr)
  );

  fpstk_tagfile #(.NREG(NREG)) u_tag (
    .clk(clk), .rst(rst), .top_nx(top_nx), .set_valid(set_valid),
    .valid_addr(valid_addr), .set_empty(set_empty), .empty_addr(empty_addr),
    .top(top_o), .tags(tags_o)
  );

  fpstk_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      stk_flt  <= 1'b0;
      inv_flt  <= 1'b0;
      cc1      <= 1'b0;
    end else begin
      rd_valid <= rd_ok;
      stk_flt  <= ovf | unf;
      inv_flt  <= ovf | unf;
      if (ovf)                 cc1 <= 1'b1;
      else if (unf || cc_clr)  cc1 <= 1'b0;
    end
  end
endmodule

// File: rtl/fpstk_ctrl_chk.sv
module fpstk_ctrl_chk
  import fpstk_pkg::*;
#(
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input logic                  clk,
  input logic                  rst,
  input logic [2:0]            cmd,
  input logic [AW-1:0]         idx,
  input logic [AW-1:0]         top_o,
  input logic [TAG_W*NREG-1:0] tags_o,
  input logic                  rd_valid,
  input logic                  stk_flt,
  input logic                  inv_flt,
  input logic                  cc1
);
  logic [AW-1:0] below, src;
  logic          below_full, src_empty;

  always_comb begin
    below      = top_o - AW'(1);
    src        = top_o + idx;
    below_full = tags_o[TAG_W*below +: TAG_W] != TAG_EMPTY;
    src_empty  = tags_o[TAG_W*src +: TAG_W] == TAG_EMPTY;
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (top_o == '0 && tags_o == '1 && !cc1 && !stk_flt));

  p_push_moves_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_PUSH && !below_full) |=>
      (top_o == AW'($past(top_o) - 1'b1) && !stk_flt));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_PUSH && below_full) |=>
      (stk_flt && cc1 && $stable(top_o) && $stable(tags_o)));

  p_underflow_read_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_READ && src_empty) |=> (stk_flt && !cc1 && !rd_valid));

  p_free_keeps_top_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_FREE) |=> ($stable(top_o) && !stk_flt));

  p_inc_wraps_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_INC) |=> (top_o == AW'($past(top_o) + 1'b1) && !cc1 && $stable(tags_o)));

  p_flags_pair_r10: assert property (@(posedge clk) disable iff (rst)
    stk_flt == inv_flt);

  p_cc1_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd == OP_NOP) |=> $stable(cc1));
endmodule

bind fpstk_ctrl fpstk_ctrl_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/fpstk_ctrl_bench.sv
module fpstk_ctrl_bench;
  localparam int NREG = 8;
  localparam int DW   = 80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [2:0]  idx = 3'd0;
  logic        pop_after = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [2:0]  top_o;
  logic [15:0] tags_o;
  logic [DW-1:0] rd_data;
  logic        rd_valid, stk_flt, inv_flt, cc1;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  fpstk_ctrl #(.NREG(NREG), .DW(DW)) u_fpstk_ctrl (
    .clk(clk), .rst(rst), .cmd(cmd), .idx(idx), .pop_after(pop_after),
    .wdata(wdata), .top_o(top_o), .tags_o(tags_o), .rd_data(rd_data),
    .rd_valid(rd_valid), .stk_flt(stk_flt), .inv_flt(inv_flt), .cc1(cc1)
  );

  // {cmd, idx, pop, token, exp top, exp fault, exp cc1, exp rd_valid, exp token}
  localparam int NV = 13;
  localparam logic [44:0] VEC [NV] = '{
    {3'd1, 3'd0, 1'b0, 16'hA111, 3'd7, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2 push, 0 -> 7
    {3'd1, 3'd0, 1'b0, 16'hB222, 3'd6, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
    {3'd6, 3'd0, 1'b0, 16'h0000, 3'd6, 1'b0, 1'b0, 1'b1, 16'hB222}, // R4 ST(0)
    {3'd6, 3'd1, 1'b0, 16'h0000, 3'd6, 1'b0, 1'b0, 1'b1, 16'hA111}, // R4 ST(1)
    {3'd6, 3'd2, 1'b0, 16'h0000, 3'd6, 1'b1, 1'b0, 1'b0, 16'h0000}, // R5 empty source
    {3'd0, 3'd0, 1'b0, 16'h0000, 3'd6, 1'b0, 1'b0, 1'b0, 16'h0000}, // R10 pulse ends
    {3'd7, 3'd1, 1'b1, 16'hC333, 3'd7, 1'b0, 1'b0, 1'b0, 16'h0000}, // R7 write ST(1)+pop
    {3'd6, 3'd0, 1'b0, 16'h0000, 3'd7, 1'b0, 1'b0, 1'b1, 16'hC333}, // R7 new ST(0)
    {3'd2, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R6 pop, 7 -> 0
    {3'd2, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0000}, // R6 empty pop
    {3'd5, 3'd0, 1'b0, 16'h0000, 3'd7, 1'b0, 1'b0, 1'b0, 16'h0000}, // R9 dec wrap
    {3'd4, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R9 inc wrap
    {3'd4, 3'd0, 1'b0, 16'h0000, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0000}  // R9
  };

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next one (one rising edge between).
  task automatic step(input logic [2:0] c, input logic [2:0] i, input logic p,
                      input logic [15:0] tok);
    cmd = c; idx = i; pop_after = p; wdata = {5{tok}};
    @(negedge clk);
    cmd = 3'd0; pop_after = 1'b0;
  endtask

  // {top, stk, inv, cc1, rd_valid, token}
  function automatic logic [95:0] obs();
    return 96'({top_o, stk_flt, inv_flt, cc1, rd_valid,
                rd_valid ? rd_data[15:0] : 16'h0000});
  endfunction

  function automatic logic [95:0] want(input logic [2:0] t, input logic f,
                                       input logic c, input logic v, input logic [15:0] d);
    return 96'({t, f, f, c, v, d});
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 reset", 96'({top_o, tags_o, cc1, stk_flt, inv_flt, rd_valid}),
          96'({3'd0, 16'hFFFF, 4'b0000}));

    // Table walk: R2 R4 R5 R6 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][44:42], VEC[v][41:39], VEC[v][38], VEC[v][37:22]);
      check($sformatf("vector %0d (R2 R4 R5 R6 R7 R9 R10)", v), obs(),
            want(VEC[v][21:19], VEC[v][18], VEC[v][17], VEC[v][16], VEC[v][15:0]));
    end
    check("R6 tags empty after pops", 96'(tags_o), 96'(16'hFFFF));

    // Fill the ring: R2
    for (int k = 0; k < 8; k++) begin
      step(3'd1, 3'd0, 1'b0, 16'h1000 + 16'(k));
      check("R2 fill push", obs(), want(3'((8 - k) % 8), 1'b0, 1'b0, 1'b0, 16'h0));
    end
    // Overflow: R3
    step(3'd1, 3'd0, 1'b0, 16'hDEAD);
    check("R3 overflow", obs(), want(3'd1, 1'b1, 1'b1, 1'b0, 16'h0));
    check("R3 tags unchanged", 96'(tags_o), 96'(16'h0000));
    // Mapping of every index, data untouched by the overflow: R4, R3; cc1 held: R10
    for (int i = 0; i < 8; i++) begin
      step(3'd6, 3'(i), 1'b0, 16'h0);
      check("R4 R10 read full ring", obs(),
            want(3'd1, 1'b0, 1'b1, 1'b1, 16'h1000 + 16'(7 - i)));
    end
    step(3'd5, 3'd0, 1'b0, 16'h0);
    check("R9 dec clears cc1", obs(), want(3'd0, 1'b0, 1'b0, 1'b0, 16'h0));

    // Free: R8
    step(3'd3, 3'd3, 1'b0, 16'h0);
    check("R8 free", 96'({top_o, stk_flt, tags_o}), 96'({3'd0, 1'b0, 16'h00C0}));
    step(3'd6, 3'd3, 1'b0, 16'h0);
    check("R8 freed reads empty", obs(), want(3'd0, 1'b1, 1'b0, 1'b0, 16'h0));
    step(3'd6, 3'd4, 1'b0, 16'h0);
    check("R8 neighbour intact", obs(), want(3'd0, 1'b0, 1'b0, 1'b1, 16'h1004));

    // Reset mid-run: R1
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", 96'({top_o, tags_o, cc1, stk_flt}),
          96'({3'd0, 16'hFFFF, 2'b00}));

    // Write without pop to an empty slot: R7
    step(3'd7, 3'd2, 1'b0, 16'h5555);
    check("R7 write no pop", 96'({top_o, stk_flt, tags_o}), 96'({3'd0, 1'b0, 16'hFFCF}));
    step(3'd6, 3'd2, 1'b0, 16'h0);
    check("R7 written value", obs(), want(3'd0, 1'b0, 1'b0, 1'b1, 16'h5555));
    // Write with pop on empty top: underflow, no data written (R7)
    step(3'd7, 3'd2, 1'b1, 16'h6666);
    check("R7 pop underflow", 96'({top_o, stk_flt, inv_flt, cc1, tags_o}),
          96'({3'd0, 3'b110, 16'hFFCF}));
    step(3'd6, 3'd2, 1'b0, 16'h0);
    check("R7 no write on fault", obs(), want(3'd0, 1'b0, 1'b0, 1'b1, 16'h5555));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule